// File: doc/BRIEF.md
# Programmable Pulse Generator Timer

This block is a 16-bit timer that produces a square wave whose period and duty are both set by software. An up-counter advances on a prescaled count-enable tick and is compared against two compare registers. The output comes from a single flip-flop that inverts whenever the counter equals either compare value. The lower compare value sets where the output enters its active phase. The upper compare value sets where it returns to idle, and that match also restarts the counter, so the upper value fixes the period.

Software reaches the timer through a small write port. The lower compare value can be double-buffered. With buffering on, a new duty value waits in a shadow register and moves into the compare register only at the period boundary, so a duty change never cuts a pulse short. The active level of the output can be selected. Each compare match gives a one-cycle interrupt pulse.

Top module: `ppg_timer`

## Requirements
- R1: After reset, `match_irq` is 0 and `pulse_out` is 1. The reset configuration is active-low output with buffering off, and the idle level of an active-low output is 1.
- R2: With count ticks on every cycle, the output stays in its active phase for (upper − lower) cycles and in its idle phase for (lower + 1) cycles. This assumes lower < upper.
- R3: On a tick where the counter equals the upper compare value, the counter returns to 0. The period is therefore (upper + 1) ticks.
- R4: The counter and the output change only on cycles where `tick` is 1. With one tick every three cycles, both phase lengths are three times their R2 values.
- R5: With buffering on, a write to the lower compare value goes to the shadow register only. The shadow value is copied into the lower compare register on the next tick that matches the upper compare value.
- R6: With buffering off, a write to the lower compare value takes effect in the same cycle's compare register update, so the next pulse already uses it.
- R7: Control bit 1 selects the active level: 1 means active-high, 0 means active-low. `pulse_out` equals the flip-flop state when active-high and its inverse when active-low.
- R8: `match_irq` is high for exactly one cycle, in the cycle after a counting tick on which the counter matched either compare value. A full period therefore carries two pulses.
- R9: While `run` is 0, the counter holds at 0, the output sits at its idle level, and no interrupt pulse is raised.
- R10: The write port decodes `wr_addr` as follows. Address 0 is the lower compare value. Address 1 is the upper compare value. Address 2 is control, with bit 0 enabling buffering and bit 1 selecting the active level. Address 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Count enable from the prescaler |
| run | input | 1 | 1 = count, 0 = stopped and cleared |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 16 | Write data |
| pulse_out | output | 1 | Square-wave output |
| match_irq | output | 1 | One-cycle pulse per compare match |

## Verification
The assertions take for granted that the lower compare value stays strictly below the upper one while the timer runs. They also assume the upper value is changed only while the timer is stopped, so the counter never passes it. The stimulus writes both compare values and the control word with `run` low, except for buffered duty updates, which are written while the timer is running. Every programmed pair keeps lower < upper. The tick pattern switches between every cycle and one cycle in three, always while the timer is stopped.

// File: rtl/ppg_timer.sv
module ppg_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick,
  input  logic         run,
  input  logic         wr_en,
  input  logic [1:0]   wr_addr,
  input  logic [W-1:0] wr_data,
  output logic         pulse_out,
  output logic         match_irq
);

  logic [W-1:0] cnt, cmp_lo, cmp_hi, lo_shadow;
  logic         buf_on, act_high, tff, irq_q;

  wire step   = run & tick;
  wire hit_lo = step & (cnt == cmp_lo);
  wire hit_hi = step & (cnt == cmp_hi);
  wire wr_lo  = wr_en & (wr_addr == 2'd0);
  wire wr_hi  = wr_en & (wr_addr == 2'd1);
  wire wr_ctl = wr_en & (wr_addr == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      tff   <= 1'b0;
      irq_q <= 1'b0;
    end else if (!run) begin
      cnt   <= '0;
      tff   <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (tick) cnt <= hit_hi ? '0 : cnt + 1'b1;
      tff   <= tff ^ hit_lo ^ hit_hi;
      irq_q <= hit_lo | hit_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_lo    <= '0;
      lo_shadow <= '0;
      cmp_hi    <= '1;
      buf_on    <= 1'b0;
      act_high  <= 1'b0;
    end else begin
      if (wr_lo && !buf_on)      cmp_lo <= wr_data;
      else if (buf_on && hit_hi) cmp_lo <= lo_shadow;
      if (wr_lo) lo_shadow <= wr_data;
      if (wr_hi) cmp_hi <= wr_data;
      if (wr_ctl) begin
        buf_on   <= wr_data[0];
        act_high <= wr_data[1];
      end
    end
  end

  assign pulse_out = tff ^ ~act_high;
  assign match_irq = irq_q;

endmodule

module ppg_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         tick,
  input logic         run,
  input logic         wr_en,
  input logic [1:0]   wr_addr,
  input logic [W-1:0] cnt,
  input logic [W-1:0] cmp_lo,
  input logic [W-1:0] cmp_hi,
  input logic         buf_on,
  input logic         act_high,
  input logic         pulse_out,
  input logic         match_irq
);

  a_r8_irq_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_irq) |-> $past(run && tick));

  a_r9_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !(wr_en && wr_addr == 2'd2) |=> pulse_out == !act_high && !match_irq && cnt == '0);

  a_r4_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick |=> $stable(cnt));

  a_r3_wrap_at_upper: assert property (@(posedge clk) disable iff (!rst_n)
    run && tick && cnt == cmp_hi |=> cnt == '0);

  a_r2_output_moves_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    run && !tick && !(wr_en && wr_addr == 2'd2) |=> $stable(pulse_out));

  a_r5_lower_held_when_buffered: assert property (@(posedge clk) disable iff (!rst_n)
    buf_on && !(run && tick && cnt == cmp_hi) |=> $stable(cmp_lo));

endmodule

bind ppg_timer ppg_timer_chk #(.W(W)) i_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .wr_en(wr_en), .wr_addr(wr_addr),
  .cnt(cnt), .cmp_lo(cmp_lo), .cmp_hi(cmp_hi), .buf_on(buf_on), .act_high(act_high),
  .pulse_out(pulse_out), .match_irq(match_irq)
);

// File: tb/test_ppg_timer.sv
`timescale 1ns/1ps
module test_ppg_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, run = 1'b0, wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [15:0] wr_data = 16'd0;
  logic pulse_out, match_irq;

  ppg_timer i_ppg_timer (.clk(clk), .rst_n(rst_n), .tick(tick), .run(run), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .pulse_out(pulse_out), .match_irq(match_irq));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  int tick_div = 1, tick_ph = 0;

  always @(negedge clk) begin
    tick_ph = (tick_ph + 1) % tick_div;
    tick <= (tick_ph == 0);
  end

  // reference model
  int m_cnt = 0, m_lo = 0, m_hi = 65535, m_sh = 0, m_ff = 0, m_irq = 0;
  bit m_buf = 0, m_pol = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_lo = 0; m_hi = 65535; m_sh = 0; m_ff = 0; m_irq = 0; m_buf = 0; m_pol = 0;
    end else begin
      bit h0, h1;
      h0 = run && tick && m_cnt == m_lo;
      h1 = run && tick && m_cnt == m_hi;
      if (!run) begin m_cnt = 0; m_ff = 0; m_irq = 0; end
      else begin
        if (tick) m_cnt = h1 ? 0 : (m_cnt + 1) % 65536;
        if (h0) m_ff = 1 - m_ff;
        if (h1) m_ff = 1 - m_ff;
        m_irq = (h0 || h1) ? 1 : 0;
      end
      if (wr_en && wr_addr == 2'd0 && !m_buf) m_lo = wr_data;
      else if (m_buf && h1) m_lo = m_sh;
      if (wr_en && wr_addr == 2'd0) m_sh = wr_data;
      if (wr_en && wr_addr == 2'd1) m_hi = wr_data;
      if (wr_en && wr_addr == 2'd2) begin m_buf = wr_data[0]; m_pol = wr_data[1]; end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    check("R7 model pulse_out", pulse_out, m_pol ? m_ff : 1 - m_ff);
    check("R8 model match_irq", match_irq, m_irq);
  end

  task automatic wr(input logic [1:0] a, input int d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d[15:0];
    @(negedge clk); wr_en = 0;
  endtask

  // returns active and idle phase lengths of the next full pulse
  task automatic measure(input bit act_lvl, output int act_n, output int idle_n);
    act_n = 0; idle_n = 0;
    @(negedge clk);
    while (pulse_out == act_lvl) @(negedge clk);
    while (pulse_out != act_lvl) @(negedge clk);
    while (pulse_out == act_lvl) begin act_n++; @(negedge clk); end
    while (pulse_out != act_lvl) begin idle_n++; @(negedge clk); end
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int a, b, n;
    repeat (3) @(negedge clk);
    check("R1 reset pulse_out", pulse_out, 1);
    check("R1 reset match_irq", match_irq, 0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R10 map: lower=0, upper=1, control=2
    wr(2'd2, 2); wr(2'd0, 2); wr(2'd1, 5); wr(2'd3, 16'hFFFF);
    run = 1;
    measure(1, a, b);
    check("R2 active length", a, 3);
    check("R3 idle length", b, 3);
    n = 0;
    for (int i = 0; i < 12; i++) begin @(negedge clk); n += match_irq; end
    check("R8 irq pulses in two periods", n, 4);

    run = 0; @(negedge clk); tick_div = 3; run = 1;
    measure(1, a, b);
    check("R4 active length slow tick", a, 9);
    check("R4 idle length slow tick", b, 9);

    run = 0; @(negedge clk); tick_div = 1;
    wr(2'd2, 0); wr(2'd0, 1); wr(2'd1, 6);
    check("R7 idle level active-low", pulse_out, 1);
    run = 1;
    measure(0, a, b);
    check("R7 active-low length", a, 5);
    check("R7 active-low idle", b, 2);

    run = 0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 5; i++) begin
      check("R9 stopped output idle", pulse_out, 1);
      check("R9 stopped no irq", match_irq, 0);
      @(negedge clk);
    end

    wr(2'd2, 2); wr(2'd0, 4);
    run = 1;
    measure(1, a, b);
    check("R6 direct write active", a, 2);

    run = 0; @(negedge clk);
    wr(2'd2, 3); wr(2'd0, 1);
    run = 1;
    measure(1, a, b);
    check("R5 buffered first pulse old duty", a, 2);
    measure(1, a, b);
    check("R5 buffered later pulse new duty", a, 5);
    wr(2'd0, 3);
    measure(1, a, b);
    measure(1, a, b);
    check("R5 running buffered update", a, 3);

    run = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule